// File: doc/BRIEF.md
# Video DC-Restore Clamp Controller

This block is the digital half of a DC-restore loop for one video input channel. The analog front end AC-couples the video signal into a sampling capacitor, and the converter's own 8-bit output code closes the loop. While an external clamp window is open, the controller compares each converted sample with a programmable target code. It then tells a current source either to pull charge off the coupling capacitor (sink) or to push charge onto it (source). Outside the window it commands nothing, so the loop only acts during the sync-locked clamp interval.

The target is chosen by a 2-bit level select that is loaded into a register by a write strobe. A parameter sets the channel type. A luma/first channel can select 16, 24, 64 or 128. A chroma/second channel cannot reach 24: on that channel the select code for 24 yields 64. After reset the luma channel holds a target of 16 and the chroma channel a target of 128. The block also reports, one cycle later, whether the sample inside the window equalled the target. This lets the user observe convergence.

Top module: `dc_clamp_ctrl`

## Requirements
- R1: On a luma channel, select codes load as target_code values 00→16, 01→24, 10→64 and 11→128. The new target is visible from the clock edge at which `level_wr` was sampled high.
- R2: On a chroma channel, select codes give 00→16, 01→64, 10→64 and 11→128. target_code never equals 24.
- R3: When clamp_gate is sampled low at an edge, both sink_o and source_o are low and idle_o is high after that edge.
- R4: When clamp_gate is sampled high and adc_code is strictly greater than target_code at an edge, sink_o is high and source_o is low after that edge.
- R5: When clamp_gate is sampled high and adc_code is less than or equal to target_code, source_o is high and sink_o is low after that edge. Equality counts as not above.
- R6: sink_o and source_o are never high together, and idle_o is high exactly when neither of them is high.
- R7: While rst is high, and after it falls, the outputs are sink_o=0, source_o=0, idle_o=1 and at_target_o=0. target_code is 16 on a luma channel and 128 on a chroma channel.
- R8: at_target_o is high after an edge exactly when clamp_gate was high and adc_code equalled target_code at that edge.
- R9: level_sel has no effect on target_code while level_wr is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_code | input | DATA_W | Converted sample from the channel's converter |
| clamp_gate | input | 1 | Clamp window, active high |
| level_wr | input | 1 | Load strobe for level_sel |
| level_sel | input | 2 | Clamp level select code |
| sink_o | output | 1 | Command: sink current to lower the input |
| source_o | output | 1 | Command: source current to raise the input |
| idle_o | output | 1 | No current command issued |
| at_target_o | output | 1 | Last gated sample equalled the target |
| target_code | output | DATA_W | Decoded clamp target code |

## Verification
On every cycle, the assertions check that the two commands stay exclusive, that a closed window forces idle, and that the command direction and the equality flag follow the comparison registered one edge earlier. They also check that the level register holds without a write and that a chroma channel never reaches 24. Only the bench's scenarios can show the exact decode table for each channel, the reset defaults, and the behaviour at the target boundary: one above, equal, one below. A bench model compares both channel variants on every clock through long runs of mixed gate, code and level-write patterns.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

    localparam int LVL_W  = 2;
    localparam int CODE_W = 8;

    typedef enum logic [LVL_W-1:0] {
        LVL_16  = 2'b00,
        LVL_24  = 2'b01,
        LVL_64  = 2'b10,
        LVL_128 = 2'b11
    } lvl_sel_e;

    typedef enum logic {
        CHAN_LUMA   = 1'b0,
        CHAN_CHROMA = 1'b1
    } chan_kind_e;

    typedef struct packed {
        logic sink;
        logic source;
        logic match;
    } clamp_cmd_t;

    // Target code for a select value; chroma cannot reach 24 and falls to 64.
    function automatic logic [CODE_W-1:0] level_code(lvl_sel_e s, chan_kind_e k);
        logic [CODE_W-1:0] c;
        case (s)
            LVL_16:  c = 8'd16;
            LVL_24:  c = (k == CHAN_CHROMA) ? 8'd64 : 8'd24;
            LVL_64:  c = 8'd64;
            default: c = 8'd128;
        endcase
        return c;
    endfunction

    function automatic lvl_sel_e reset_sel(chan_kind_e k);
        return (k == CHAN_CHROMA) ? LVL_128 : LVL_16;
    endfunction

endpackage

// File: rtl/clamp_level_reg.sv
module clamp_level_reg
    import clamp_pkg::*;
#(
    parameter chan_kind_e CHAN_KIND = CHAN_LUMA,
    parameter int         DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LVL_W-1:0]  sel_in,
    output logic [DATA_W-1:0] target_o
);

    lvl_sel_e sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= reset_sel(CHAN_KIND);
        end else if (wr_en) begin
            sel_q <= lvl_sel_e'(sel_in);
        end
    end

    always_comb begin
        target_o = DATA_W'(level_code(sel_q, CHAN_KIND));
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (sel_q == $past(sel_q)));   // R9

    generate
        if (CHAN_KIND == CHAN_CHROMA) begin : g_chroma_chk
            AST_NO_LEVEL_24: assert property (@(posedge clk) disable iff (rst)
                target_o != DATA_W'(24));   // R2
        end
    endgenerate

endmodule

// File: rtl/clamp_compare.sv
module clamp_compare
    import clamp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] sample_i,
    input  logic [DATA_W-1:0] target_i,
    output clamp_cmd_t        want_o
);

    logic above;

    always_comb begin
        above         = (sample_i > target_i);
        want_o.sink   = above;
        want_o.source = !above;
        want_o.match  = (sample_i == target_i);
    end

endmodule

// File: rtl/clamp_drive.sv
module clamp_drive
    import clamp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       gate_i,
    input  clamp_cmd_t want_i,
    output clamp_cmd_t cmd_o,
    output logic       idle_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o  <= '0;
            idle_o <= 1'b1;
        end else if (gate_i) begin
            cmd_o  <= want_i;
            idle_o <= !(want_i.sink || want_i.source);
        end else begin
            cmd_o  <= '0;
            idle_o <= 1'b1;
        end
    end

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_o.sink, cmd_o.source}));   // R6

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
        !gate_i |=> (idle_o && !cmd_o.sink && !cmd_o.source && !cmd_o.match));   // R3

endmodule

// File: rtl/dc_clamp_ctrl.sv
module dc_clamp_ctrl
    import clamp_pkg::*;
#(
    parameter chan_kind_e CHAN_KIND = CHAN_LUMA,
    parameter int         DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] adc_code,
    input  logic              clamp_gate,
    input  logic              level_wr,
    input  logic [1:0]        level_sel,
    output logic              sink_o,
    output logic              source_o,
    output logic              idle_o,
    output logic              at_target_o,
    output logic [DATA_W-1:0] target_code
);

    clamp_cmd_t want;
    clamp_cmd_t cmd;

    clamp_level_reg #(.CHAN_KIND(CHAN_KIND), .DATA_W(DATA_W)) u_level (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (level_wr),
        .sel_in   (level_sel),
        .target_o (target_code)
    );

    clamp_compare #(.DATA_W(DATA_W)) u_cmp (
        .sample_i (adc_code),
        .target_i (target_code),
        .want_o   (want)
    );

    clamp_drive u_drive (
        .clk    (clk),
        .rst    (rst),
        .gate_i (clamp_gate),
        .want_i (want),
        .cmd_o  (cmd),
        .idle_o (idle_o)
    );

    assign sink_o      = cmd.sink;
    assign source_o    = cmd.source;
    assign at_target_o = cmd.match;

    AST_SINK_ABOVE: assert property (@(posedge clk) disable iff (rst)
        (clamp_gate && adc_code > target_code) |=> (sink_o && !source_o));   // R4

    AST_SOURCE_NOT_ABOVE: assert property (@(posedge clk) disable iff (rst)
        (clamp_gate && adc_code <= target_code) |=> (source_o && !sink_o));   // R5

    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
        (clamp_gate && adc_code == target_code) |=> at_target_o);   // R8

    AST_IDLE_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
        idle_o == !(sink_o || source_o));   // R6

endmodule

// File: tb/dc_clamp_ctrl_tb.sv
module dc_clamp_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] adc_code;
    logic       clamp_gate;
    logic       level_wr;
    logic [1:0] level_sel;

    logic       a_sink, a_src, a_idle, a_match;
    logic [7:0] a_tgt;
    logic       b_sink, b_src, b_idle, b_match;
    logic [7:0] b_tgt;

    int checks = 0;
    int errors = 0;

    // model state
    int m_sel_a = 0;
    int m_sel_b = 3;
    bit e_sink_a, e_src_a, e_match_a;
    bit e_sink_b, e_src_b, e_match_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    dc_clamp_ctrl #(.CHAN_KIND(clamp_pkg::CHAN_LUMA), .DATA_W(8)) u_dut (
        .clk(clk), .rst(rst), .adc_code(adc_code), .clamp_gate(clamp_gate),
        .level_wr(level_wr), .level_sel(level_sel),
        .sink_o(a_sink), .source_o(a_src), .idle_o(a_idle),
        .at_target_o(a_match), .target_code(a_tgt)
    );

    dc_clamp_ctrl #(.CHAN_KIND(clamp_pkg::CHAN_CHROMA), .DATA_W(8)) u_dut_b (
        .clk(clk), .rst(rst), .adc_code(adc_code), .clamp_gate(clamp_gate),
        .level_wr(level_wr), .level_sel(level_sel),
        .sink_o(b_sink), .source_o(b_src), .idle_o(b_idle),
        .at_target_o(b_match), .target_code(b_tgt)
    );

    function automatic int tgt_of(int sel, bit chroma);
        if (sel == 0) return 16;
        if (sel == 1) return chroma ? 64 : 24;
        if (sel == 2) return 64;
        return 128;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        check(req, "A target", a_tgt, tgt_of(m_sel_a, 1'b0));
        check(req, "A sink", a_sink, e_sink_a);
        check(req, "A source", a_src, e_src_a);
        check(req, "A idle", a_idle, !(e_sink_a || e_src_a));
        check(req, "A match", a_match, e_match_a);
        check(req, "B target", b_tgt, tgt_of(m_sel_b, 1'b1));
        check(req, "B sink", b_sink, e_sink_b);
        check(req, "B source", b_src, e_src_b);
        check(req, "B idle", b_idle, !(e_sink_b || e_src_b));
        check(req, "B match", b_match, e_match_b);
        check("R6", "A exclusive", int'(a_sink && a_src), 0);
        check("R6", "B exclusive", int'(b_sink && b_src), 0);
    endtask

    // drive at negedge, model the edge, compare at next negedge
    task automatic step(int code, bit gate, bit wr, int sel, string req);
        int ta, tb;
        adc_code   = 8'(code);
        clamp_gate = gate;
        level_wr   = wr;
        level_sel  = 2'(sel);
        @(posedge clk);
        ta = tgt_of(m_sel_a, 1'b0);
        tb = tgt_of(m_sel_b, 1'b1);
        e_sink_a  = gate && (code > ta);
        e_src_a   = gate && !(code > ta);
        e_match_a = gate && (code == ta);
        e_sink_b  = gate && (code > tb);
        e_src_b   = gate && !(code > tb);
        e_match_b = gate && (code == tb);
        if (wr) begin
            m_sel_a = sel;
            m_sel_b = sel;
        end
        @(negedge clk);
        compare_all(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; adc_code = 8'd200; clamp_gate = 1'b1;
        level_wr = 1'b1; level_sel = 2'd2;
        repeat (3) @(negedge clk);
        // R7: reset state even with gate and write active
        e_sink_a = 0; e_src_a = 0; e_match_a = 0;
        e_sink_b = 0; e_src_b = 0; e_match_b = 0;
        compare_all("R7");
        rst = 1'b0;
        step(0, 1'b0, 1'b0, 0, "R7");

        // R9: select changes without strobe are ignored
        step(50, 1'b0, 1'b0, 2, "R9");
        step(50, 1'b0, 1'b0, 1, "R9");

        // R1 / R2: decode each select on both channel kinds
        for (int s = 0; s < 4; s++) begin
            step(0, 1'b0, 1'b1, s, "R1");
            step(0, 1'b0, 1'b0, s, "R2");
        end

        // select 01: luma 24, chroma 64
        step(0, 1'b0, 1'b1, 1, "R2");
        step(25, 1'b1, 1'b0, 0, "R4");
        step(24, 1'b1, 1'b0, 0, "R8");
        step(64, 1'b1, 1'b0, 0, "R8");
        step(65, 1'b1, 1'b0, 0, "R4");
        step(23, 1'b1, 1'b0, 0, "R5");

        // select 00: both 16
        step(0, 1'b0, 1'b1, 0, "R1");
        step(200, 1'b1, 1'b0, 0, "R4");
        step(16, 1'b1, 1'b0, 0, "R5");
        step(15, 1'b1, 1'b0, 0, "R5");
        step(0, 1'b1, 1'b0, 0, "R5");
        step(200, 1'b0, 1'b0, 0, "R3");
        step(16, 1'b0, 1'b0, 0, "R3");

        // select 11: both 128, boundary around target
        step(0, 1'b0, 1'b1, 3, "R1");
        step(129, 1'b1, 1'b0, 3, "R4");
        step(128, 1'b1, 1'b0, 3, "R8");
        step(127, 1'b1, 1'b0, 3, "R5");
        step(255, 1'b1, 1'b0, 3, "R4");
        step(255, 1'b0, 1'b0, 3, "R3");

        // write and gate in the same cycle: compare uses old target
        step(20, 1'b1, 1'b1, 0, "R4");
        step(20, 1'b1, 1'b0, 0, "R4");

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            step((i * 37 + 11) % 256, (i % 3) != 0, (i % 7) == 0, (i / 7) % 4, "R6");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule